// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block measures the bit time of the first character a host sends, and turns that measurement into a 16-bit baud divisor for a UART receiver. The host is expected to start with an ASCII `A` (0x41) or `a` (0x61). Software pulses a start input. The block arms itself and waits for the falling edge that opens the start bit on the receive line. It then counts clock cycles that carry a prescale enable, until a chosen closing edge arrives. The count is converted to a divisor and written to the divisor latch.

There are two timing modes. With mode select at 0, the closing edge is the next falling edge. That spans two bit times: the start bit and the character's bit 0, which is a 1 in both `A` and `a`, while bit 1 is a 0. With mode select at 1, the closing edge is the next rising edge, which gives one bit time. The count keeps four bits below the divisor's resolution, one divisor step per sixteen counted cycles.

On success the block loads the divisor, pulses a strobe and sets a sticky end flag if that flag is enabled. If the counter runs out before the closing edge, the measurement aborts and a sticky timeout flag is set if enabled. Each flag falls only when its clear input is pulsed.

Top module: `autobaud_meter`

## Requirements
- R1: While reset is held and in the first cycle after it, `divisor` is 0 and `div_load`, `eom_flag`, `tmo_flag` and `busy` are all 0.
- R2: A one-cycle pulse on `start_set` makes `busy` 1 from the next cycle. A pulse on `start_set` while `busy` is 1 discards the measurement in progress, and the block again waits for a falling edge. A rising edge seen while waiting for that falling edge does nothing.
- R3: In mode 1 (`mode_sel` = 1), N is the number of cycles with `tick_en` = 1, counted from the falling edge on `rxd` up to the next rising edge. The new divisor is floor(N / 16).
- R4: In mode 0 (`mode_sel` = 0), N is counted from the falling edge up to the next falling edge, and a rising edge in between does not stop the count. The new divisor is floor(N / 32).
- R5: A computed divisor of 0 is loaded as 1.
- R6: Only cycles with `tick_en` = 1 add to N.
- R7: The counter is DIV_W+SUB_W bits wide. When N would go past 2^(DIV_W+SUB_W)−1 before the closing edge, the measurement aborts: `busy` falls, `div_load` stays 0 and `divisor` keeps its old value. `tmo_flag` is set if `tmo_ie` = 1.
- R8: The third rising clock edge after the closing edge's level change on `rxd` loads `divisor`. On that same edge `div_load` goes high for exactly one cycle, `busy` falls, and `eom_flag` is set if `eom_ie` = 1. `divisor` changes at no other time.
- R9: `eom_flag` and `tmo_flag` stay set until their own clear input (`eom_clr`, `tmo_clr`) is pulsed, and they read 0 in the cycle after the clear.
- R10: The mode is sampled at the `start_set` pulse. Changing `mode_sel` later does not affect that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| tick_en | input | 1 | Prescale enable; a cycle counts only when this is high |
| mode_sel | input | 1 | 0: two-bit span from fall to fall; 1: one bit from fall to rise |
| start_set | input | 1 | Pulse to arm, or re-arm, a measurement |
| eom_ie | input | 1 | Enable for the end-of-measurement flag |
| tmo_ie | input | 1 | Enable for the timeout flag |
| eom_clr | input | 1 | Pulse to clear `eom_flag` |
| tmo_clr | input | 1 | Pulse to clear `tmo_flag` |
| divisor | output | DIV_W | Baud divisor latch |
| div_load | output | 1 | One-cycle strobe when `divisor` is loaded |
| eom_flag | output | 1 | Sticky end-of-measurement status |
| tmo_flag | output | 1 | Sticky counter-overflow status |
| busy | output | 1 | High from arming until finish or abort |

## Verification
Each level change on `rxd` reaches the control state on the third rising clock edge after it is driven: two synchronizer flops, then the edge decision. Because the bench drives `rxd` and `tick_en` on falling clock edges, it samples `div_load`, `divisor`, `busy` and `eom_flag` on exactly the third falling edge after driving the closing edge. It computes N by summing the `tick_en` values it drove on the falling edges from two after the opening edge to one after the closing edge. `busy` is due one cycle after `start_set`, and each flag clear is checked one cycle after its pulse. Timeout runs are judged once the line pattern has finished, by the flag, the unchanged divisor and the absence of any strobe.

// File: rtl/abm_pkg.sv
// Package abm_pkg
// Types shared by the auto-baud measurement blocks.
// Assumes: nothing beyond a common clock domain for all users.
package abm_pkg;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        ABM_IDLE  = 2'd0,
        ABM_ARMED = 2'd1,
        ABM_COUNT = 2'd2
    } abm_state_e;

    // Index of each sticky status flag in the flag bank
    localparam int unsigned FLAG_EOM = 0;
    localparam int unsigned FLAG_TMO = 1;
    localparam int unsigned NUM_FLAGS = 2;

endpackage

// File: rtl/abm_line_sync.sv
// Module abm_line_sync
// Brings the asynchronous receive line into the clock domain through a
// flop chain. It then flags single-cycle falling and rising edges found on
// the synchronized level.
// Assumes: SYNC_STAGES >= 2; the line idles high, so the chain resets to 1.
module abm_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   level;
    logic                   level_prev_q;

    assign level = chain_q[SYNC_STAGES-1];

    // Shift the raw line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], line_i};
        end
    end

    // Keep the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_prev_q <= 1'b1;
        end else begin
            level_prev_q <= level;
        end
    end

    // Edge pulses derived from synchronized samples only
    always_comb begin
        fall_o = level_prev_q & ~level;
        rise_o = ~level_prev_q & level;
    end

endmodule

// File: rtl/abm_meter.sv
// Module abm_meter
// Measurement counter with a sub-count below divisor resolution. It counts
// enabled cycles and reports overflow. It also forms the divisor: the count
// shifted down by SUB_W, or by SUB_W+1 when two bit times were measured,
// with a zero result forced to 1.
// Assumes: clear_i wins over begin_i, and begin_i wins over run_i.
module abm_meter #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             begin_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             half_i,
    output logic             ovf_o,
    output logic [DIV_W-1:0] quot_o
);

    localparam int unsigned CNT_W = DIV_W + SUB_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] shifted;
    logic [DIV_W-1:0] quot_raw;

    // Count enabled cycles; the opening cycle counts if enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (begin_i) begin
            cnt_q <= {{(CNT_W-1){1'b0}}, tick_i};
        end else if (run_i && tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Overflow when one more enabled cycle arrives at full count
    always_comb begin
        ovf_o = run_i & tick_i & (cnt_q == CNT_MAX);
    end

    // Divide by 16 per measured bit and floor the result at 1
    always_comb begin
        shifted  = half_i ? (cnt_q >> (SUB_W + 1)) : (cnt_q >> SUB_W);
        quot_raw = shifted[DIV_W-1:0];
        quot_o   = (quot_raw == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : quot_raw;
    end

endmodule

// File: rtl/abm_ctrl.sv
// Module abm_ctrl
// Sequencer for one measurement: idle, armed (waiting for the opening
// falling edge), counting (waiting for the closing edge or overflow).
// It latches the mode at start and owns the divisor latch and load strobe.
// Assumes: edge inputs are single-cycle pulses from the synchronizer.
module abm_ctrl
    import abm_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             fall_i,
    input  logic             rise_i,
    input  logic             ovf_i,
    input  logic [DIV_W-1:0] quot_i,
    output logic             clear_o,
    output logic             begin_o,
    output logic             run_o,
    output logic             half_o,
    output logic             finish_o,
    output logic             abort_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             load_o,
    output logic             busy_o
);

    abm_state_e       state_q;
    abm_state_e       state_d;
    logic             mode_q;
    logic             stop_edge;
    logic [DIV_W-1:0] divisor_q;
    logic             load_q;

    // Closing edge depends on the mode latched at start
    always_comb begin
        half_o    = ~mode_q;
        stop_edge = mode_q ? rise_i : fall_i;
    end

    // Counter commands and completion events for this cycle
    always_comb begin
        clear_o  = start_i;
        begin_o  = (state_q == ABM_ARMED) & fall_i & ~start_i;
        run_o    = (state_q == ABM_COUNT) & ~stop_edge & ~start_i;
        finish_o = (state_q == ABM_COUNT) & stop_edge & ~start_i;
        abort_o  = (state_q == ABM_COUNT) & ovf_i & ~start_i;
    end

    // Next-state choice; a new start always re-arms
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ABM_ARMED;
        end else begin
            case (state_q)
                ABM_ARMED: if (fall_i) state_d = ABM_COUNT;
                ABM_COUNT: if (finish_o || abort_o) state_d = ABM_IDLE;
                default:   state_d = ABM_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ABM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sample the mode only when a measurement is started
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (start_i) begin
            mode_q <= mode_i;
        end
    end

    // Divisor latch and its one-cycle load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor_q <= '0;
            load_q    <= 1'b0;
        end else begin
            load_q <= finish_o;
            if (finish_o) begin
                divisor_q <= quot_i;
            end
        end
    end

    assign divisor_o = divisor_q;
    assign load_o    = load_q;
    assign busy_o    = (state_q != ABM_IDLE);

endmodule

// File: rtl/abm_flags.sv
// Module abm_flags
// Bank of sticky status flags. Each flag sets on its event when enabled and
// clears only on its own clear input. A set and a clear in the same cycle
// leave the flag set, so no event is lost.
// Assumes: all inputs are synchronous single-cycle pulses or levels.
module abm_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_i,
    input  logic [N-1:0] enable_i,
    input  logic [N-1:0] clear_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;

        // Sticky flag: set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (event_i[g] && enable_i[g]) begin
                flag_q <= 1'b1;
            end else if (clear_i[g]) begin
                flag_q <= 1'b0;
            end
        end

        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/autobaud_meter.sv
// Module autobaud_meter
// Auto-baud detector top. It synchronizes the receive line, times the
// opening bit (or bits) of an 'A'/'a' character in enabled clock cycles,
// and writes the resulting baud divisor with a load strobe and status flags.
// Assumes: tick_en stands in for any prescaler; mode 0 relies on bit 0 of
// the character being 1 and bit 1 being 0.
module autobaud_meter
    import abm_pkg::*;
#(
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned SUB_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             tick_en,
    input  logic             mode_sel,
    input  logic             start_set,
    input  logic             eom_ie,
    input  logic             tmo_ie,
    input  logic             eom_clr,
    input  logic             tmo_clr,
    output logic [DIV_W-1:0] divisor,
    output logic             div_load,
    output logic             eom_flag,
    output logic             tmo_flag,
    output logic             busy
);

    logic                 fall;
    logic                 rise;
    logic                 cnt_clear;
    logic                 cnt_begin;
    logic                 cnt_run;
    logic                 half;
    logic                 ovf;
    logic                 finish;
    logic                 abort;
    logic [DIV_W-1:0]     quot;
    logic [NUM_FLAGS-1:0] flag_evt;
    logic [NUM_FLAGS-1:0] flag_en;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flags;

    abm_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rxd),
        .fall_o (fall),
        .rise_o (rise)
    );

    abm_meter #(
        .DIV_W(DIV_W),
        .SUB_W(SUB_W)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .begin_i (cnt_begin),
        .run_i   (cnt_run),
        .tick_i  (tick_en),
        .half_i  (half),
        .ovf_o   (ovf),
        .quot_o  (quot)
    );

    abm_ctrl #(
        .DIV_W(DIV_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_set),
        .mode_i    (mode_sel),
        .fall_i    (fall),
        .rise_i    (rise),
        .ovf_i     (ovf),
        .quot_i    (quot),
        .clear_o   (cnt_clear),
        .begin_o   (cnt_begin),
        .run_o     (cnt_run),
        .half_o    (half),
        .finish_o  (finish),
        .abort_o   (abort),
        .divisor_o (divisor),
        .load_o    (div_load),
        .busy_o    (busy)
    );

    // Route completion events, enables and clears into the flag bank
    always_comb begin
        flag_evt           = '0;
        flag_en            = '0;
        flag_clr           = '0;
        flag_evt[FLAG_EOM] = finish;
        flag_evt[FLAG_TMO] = abort;
        flag_en[FLAG_EOM]  = eom_ie;
        flag_en[FLAG_TMO]  = tmo_ie;
        flag_clr[FLAG_EOM] = eom_clr;
        flag_clr[FLAG_TMO] = tmo_clr;
    end

    abm_flags #(
        .N(NUM_FLAGS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (flag_evt),
        .enable_i (flag_en),
        .clear_i  (flag_clr),
        .flag_o   (flags)
    );

    assign eom_flag = flags[FLAG_EOM];
    assign tmo_flag = flags[FLAG_TMO];

endmodule

// File: rtl/abm_checker.sv
// Module abm_checker
// Temporal checks on the auto-baud detector ports, bound into every
// instance of the top module.
// Assumes: synchronous active-low reset on rst_n.
module abm_checker #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_set,
    input logic             eom_clr,
    input logic             tmo_clr,
    input logic [DIV_W-1:0] divisor,
    input logic             div_load,
    input logic             eom_flag,
    input logic             tmo_flag,
    input logic             busy
);

    a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        start_set |=> busy);

    a_r5_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> (divisor != '0));

    a_r8_load_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> (!busy && $past(busy)));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !div_load);

    a_r8_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !div_load |-> $stable(divisor));

    a_r8_eom_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eom_flag) |-> div_load);

    a_r7_tmo_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> (!busy && !div_load && $past(busy)));

    a_r9_eom_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eom_flag && !eom_clr) |=> eom_flag);

    a_r9_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !tmo_clr) |=> tmo_flag);

endmodule

bind autobaud_meter abm_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_set (start_set),
    .eom_clr   (eom_clr),
    .tmo_clr   (tmo_clr),
    .divisor   (divisor),
    .div_load  (div_load),
    .eom_flag  (eom_flag),
    .tmo_flag  (tmo_flag),
    .busy      (busy)
);

// File: tb/sim_autobaud_meter.sv
module sim_autobaud_meter;

    localparam int DW   = 8;
    localparam int SW   = 4;
    localparam int CMAX = (1 << (DW + SW)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          tick_en = 1'b1;
    logic          mode_sel = 1'b1;
    logic          start_set = 1'b0;
    logic          eom_ie = 1'b1;
    logic          tmo_ie = 1'b1;
    logic          eom_clr = 1'b0;
    logic          tmo_clr = 1'b0;
    logic [DW-1:0] divisor;
    logic          div_load;
    logic          eom_flag;
    logic          tmo_flag;
    logic          busy;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    autobaud_meter #(.DIV_W(DW), .SUB_W(SW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick_en(tick_en),
        .mode_sel(mode_sel), .start_set(start_set), .eom_ie(eom_ie),
        .tmo_ie(tmo_ie), .eom_clr(eom_clr), .tmo_clr(tmo_clr),
        .divisor(divisor), .div_load(div_load), .eom_flag(eom_flag),
        .tmo_flag(tmo_flag), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input bit md);
        @(negedge clk);
        mode_sel  = md;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        eom_clr = 1'b1;
        tmo_clr = 1'b1;
        @(negedge clk);
        eom_clr = 1'b0;
        tmo_clr = 1'b0;
        check(eom_flag == 1'b0, "R9 eom cleared", int'(eom_flag), 0);
        check(tmo_flag == 1'b0, "R9 tmo cleared", int'(tmo_flag), 0);
    endtask

    function automatic bit tick_at(input int i, input bit gated);
        return gated ? ((i % 3) == 0) : 1'b1;
    endfunction

    // One character: opening fall at index I0, closing edge at index is
    task automatic run_char(input bit md, input int len, input bit gated, input bit flip);
        int  i0, ist, n, cnt, expd, nload;
        bit  to;
        logic [DW-1:0] prev;
        i0    = 4;
        ist   = md ? i0 + len : i0 + 2 * len;
        n     = ist + 8;
        nload = 0;
        prev  = divisor;
        cnt   = 0;
        for (int j = i0 + 2; j <= ist + 1; j++) cnt += int'(tick_at(j, gated));
        to    = (cnt > CMAX);
        expd  = md ? (cnt >> SW) : (cnt >> (SW + 1));
        if (expd == 0) expd = 1;
        pulse_start(md);
        if (flip) mode_sel = ~md;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (div_load) nload++;
            if (!to && i == ist + 3) begin
                check(div_load == 1'b1, "R8 load strobe", int'(div_load), 1);
                check(busy == 1'b0, "R8 busy low at load", int'(busy), 0);
                check(eom_flag == eom_ie, "R8 eom flag", int'(eom_flag), int'(eom_ie));
                if (md)
                    check(int'(divisor) == expd, "R3 R5 R6 mode1 divisor", int'(divisor), expd);
                else
                    check(int'(divisor) == expd, "R4 R5 R10 mode0 divisor", int'(divisor), expd);
            end
            tick_en = tick_at(i, gated);
            if (i < i0)                     rxd = 1'b1;
            else if (md)                    rxd = (i < ist) ? 1'b0 : 1'b1;
            else if (i < i0 + len)          rxd = 1'b0;
            else if (i < ist)               rxd = 1'b1;
            else if (i < ist + 3)           rxd = 1'b0;
            else                            rxd = 1'b1;
        end
        tick_en = 1'b1;
        if (to) begin
            check(nload == 0, "R7 no load on overflow", nload, 0);
            check(divisor == prev, "R7 divisor kept", int'(divisor), int'(prev));
            check(busy == 1'b0, "R7 busy dropped", int'(busy), 0);
            check(tmo_flag == tmo_ie, "R7 tmo flag", int'(tmo_flag), int'(tmo_ie));
        end else begin
            check(nload == 1, "R8 one strobe", nload, 1);
            check(eom_flag == eom_ie, "R9 eom sticky", int'(eom_flag), int'(eom_ie));
        end
        clear_flags();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nl;
        repeat (3) @(negedge clk);
        check(divisor == 0 && !div_load && !busy, "R1 in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(divisor == 0, "R1 divisor", int'(divisor), 0);
        check(!eom_flag && !tmo_flag && !div_load && !busy, "R1 status", int'(busy), 0);

        // Near-exhaustive short lengths, both modes (R3 R4 R5)
        for (int l = 1; l <= 80; l++) run_char(1'b1, l, 1'b0, 1'b0);
        for (int l = 1; l <= 80; l++) run_char(1'b0, l, 1'b0, 1'b0);
        // Long lengths across the counter range
        for (int l = 100; l <= CMAX; l += 151) run_char(1'b1, l, 1'b0, 1'b0);
        for (int l = 100; l <= CMAX / 2; l += 151) run_char(1'b0, l, 1'b0, 1'b0);
        run_char(1'b1, CMAX, 1'b0, 1'b0);           // R3 top of range
        run_char(1'b0, (CMAX + 1) / 2 - 1, 1'b0, 1'b0);
        // R6 gated counting
        for (int l = 20; l <= 400; l += 57) run_char(1'b1, l, 1'b1, 1'b0);
        for (int l = 20; l <= 400; l += 57) run_char(1'b0, l, 1'b1, 1'b0);
        // R10 mode changes after start are ignored
        run_char(1'b0, 70, 1'b0, 1'b1);
        run_char(1'b1, 70, 1'b0, 1'b1);
        // R7 overflow in both modes, enabled and disabled flag
        run_char(1'b1, CMAX + 1, 1'b0, 1'b0);
        run_char(1'b0, (CMAX + 1) / 2, 1'b0, 1'b0);
        tmo_ie = 1'b0;
        run_char(1'b1, CMAX + 1, 1'b0, 1'b0);
        tmo_ie = 1'b1;
        // R8 end flag disabled still loads
        eom_ie = 1'b0;
        run_char(1'b1, 50, 1'b0, 1'b0);
        eom_ie = 1'b1;

        // R2 restart while busy, then a rise while re-armed is ignored
        pulse_start(1'b1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (20) @(negedge clk);
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        nl = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (div_load) nl++;
        end
        check(nl == 0, "R2 rise ignored after restart", nl, 0);
        check(busy == 1'b1, "R2 still armed", int'(busy), 1);
        run_char(1'b1, 90, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule